// File: doc/BRIEF.md
# Thread-Group Branch and Lane-Mask Sequencer

This block steers control flow for one group of lanes that run the same 64-bit instruction stream in lockstep. It keeps the group's program counter and two lane masks. The active mask records which lanes currently execute. The exited mask records which lanes have terminated. Only three instructions are interpreted: a conditional branch, a mask resynchronisation and a lane exit. Every other opcode only advances the program counter.

A branch tests one or more flag components (X, Y, Z, W) of every active lane. When at least one active lane passes the test, the group jumps to the target. Lanes that fail the test are switched off until a later resynchronisation turns them back on. A taken jump costs one dead cycle, because nothing is predicted. When the last lane exits, the block pulses a completion signal and then holds still until reset.

Top module: `simt_branch_seq`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) sets the program counter to 0, all lanes active and no lanes exited, with `bubble`, `illegal` and `group_done` low.
- R2: The opcode is instruction bits 63:56. An accepted instruction whose opcode is not 0x80, 0x01 or 0x00 advances the PC by one and leaves the active mask unchanged. An instruction is accepted only when `instr_valid` is high; otherwise nothing changes.
- R3: Opcode 0x80 is a branch. Its component select is bits 55:52 (bit 52 = X, 53 = Y, 54 = Z, 55 = W) and its target is bits 41:32. Lane i presents its flags on `lane_flags[4i+3:4i]`, with X in bit 0 and W in bit 3. An active lane passes when all of its selected flag bits are 1. If any active lane passes, the PC becomes the target and the active mask becomes the set of passing lanes.
- R4: When no active lane passes a branch, the PC advances by one and the active mask is unchanged. Flags of inactive lanes are never considered.
- R5: A branch with any of bits 51:42 or 31:0 set raises `illegal` for exactly one cycle, and the PC and the mask stay unchanged.
- R6: A taken branch raises `bubble` for exactly the following cycle. An instruction presented during that cycle is discarded.
- R7: Opcode 0x01 makes every non-exited lane active and advances the PC by one.
- R8: Opcode 0x00 moves every active lane into the exited set, leaves no lane active and advances the PC by one. No lane is ever both active and exited.
- R9: When an exit makes every lane exited, `group_done` is high for exactly one cycle. After that, all instructions are ignored until reset.
- R10: A branch with an all-zero component select passes in every active lane. It acts as an unconditional jump that leaves the mask unchanged.
- R11: The PC wraps from its maximum value (1023) to 0 when it advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 64 | Instruction word |
| lane_flags | input | LANES*4 | Per-lane flag components, X in the lowest bit of each nibble |
| pc | output | PC_W | Address of the next instruction to fetch |
| active_mask | output | LANES | Lanes that currently execute |
| bubble | output | 1 | The current cycle is the dead slot after a taken branch |
| illegal | output | 1 | The previous branch had reserved bits set |
| group_done | output | 1 | One-cycle pulse when the last lane has exited |

## Verification
The bench builds the block with four lanes and a 10-bit program counter. With these values the whole target field is usable, so a jump to address 1023 followed by one step reaches the wrap to zero. Four lanes are enough to form split masks such as 0101 and 1010. They are also enough to present a branch whose only passing lane is inactive, and to reach retirement through two separate exits joined by a resynchronisation.

// File: rtl/simt_seq_pkg.sv
package simt_seq_pkg;

   localparam int unsigned WORD_W    = 64;
   localparam int unsigned COMP_N    = 4;
   localparam int unsigned TARGET_W  = 10;

   localparam logic [7:0] OPC_BRANCH = 8'h80;
   localparam logic [7:0] OPC_RESYNC = 8'h01;
   localparam logic [7:0] OPC_RETIRE = 8'h00;

   typedef enum logic [1:0] {
      CF_PLAIN  = 2'd0,
      CF_BRANCH = 2'd1,
      CF_RESYNC = 2'd2,
      CF_RETIRE = 2'd3
   } cf_kind_e;

   typedef struct packed {
      cf_kind_e              kind;
      logic [COMP_N-1:0]     comp_sel;
      logic [TARGET_W-1:0]   target;
      logic                  rsv_bad;
   } cf_decode_t;

endpackage

// File: rtl/simt_instr_decode.sv
module simt_instr_decode
   import simt_seq_pkg::*;
#(
   parameter int unsigned INSTR_W = 64
) (
   input  logic [INSTR_W-1:0] instr_i,
   output cf_decode_t         dec_o
);

   localparam int unsigned OPC_LSB = INSTR_W - 8;

   if (INSTR_W != WORD_W) begin : g_bad_width
      $error("simt_instr_decode: INSTR_W must equal 64");
   end

   logic [7:0] opc;
   assign opc = instr_i[OPC_LSB +: 8];

   always_comb begin
      dec_o.comp_sel = instr_i[55:52];
      dec_o.target   = instr_i[41:32];
      unique case (opc)
         OPC_BRANCH: dec_o.kind = CF_BRANCH;
         OPC_RESYNC: dec_o.kind = CF_RESYNC;
         OPC_RETIRE: dec_o.kind = CF_RETIRE;
         default:    dec_o.kind = CF_PLAIN;
      endcase
      dec_o.rsv_bad = (opc == OPC_BRANCH) &&
                      ((|instr_i[51:42]) || (|instr_i[31:0]));
   end

endmodule

// File: rtl/simt_lane_cond.sv
module simt_lane_cond
   import simt_seq_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic [LANES*COMP_N-1:0] flags_i,
   input  logic [COMP_N-1:0]       sel_i,
   input  logic [LANES-1:0]        active_i,
   output logic [LANES-1:0]        pass_o,
   output logic                    any_pass_o
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [COMP_N-1:0] lane_f;
      assign lane_f    = flags_i[g*COMP_N +: COMP_N];
      // unselected components read as 1, so an empty select always passes
      assign pass_o[g] = active_i[g] & (&(lane_f | ~sel_i));
   end

   assign any_pass_o = |pass_o;

endmodule

// File: rtl/simt_lane_mask.sv
module simt_lane_mask #(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic [LANES-1:0] pass_i,
   input  logic             resync_i,
   input  logic             retire_i,
   output logic [LANES-1:0] active_o,
   output logic [LANES-1:0] exited_o,
   output logic             done_o
);

   localparam logic [LANES-1:0] ALL_LANES = {LANES{1'b1}};

   logic [LANES-1:0] active_q, exited_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= ALL_LANES;
         exited_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (take_i) begin
            active_q <= pass_i;
         end else if (resync_i) begin
            active_q <= ~exited_q;
         end else if (retire_i) begin
            exited_q <= exited_q | active_q;
            active_q <= '0;
            done_q   <= ((exited_q | active_q) == ALL_LANES);
         end
      end
   end

   assign active_o = active_q;
   assign exited_o = exited_q;
   assign done_o   = done_q;

   assert_disjoint_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q & exited_q) == '0);

   assert_take_only_narrows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> ((active_q & ~$past(active_q)) == '0));

   assert_resync_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resync_i |=> (active_q == ~exited_q));

   assert_retire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      retire_i |=> (active_q == '0));

   assert_done_all_exited_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (exited_q == ALL_LANES));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/simt_branch_seq.sv
module simt_branch_seq
   import simt_seq_pkg::*;
#(
   parameter int unsigned LANES    = 4,
   parameter int unsigned PC_W     = 10,
   parameter int unsigned RESET_PC = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    instr_valid,
   input  logic [63:0]             instr,
   input  logic [LANES*4-1:0]      lane_flags,
   output logic [PC_W-1:0]         pc,
   output logic [LANES-1:0]        active_mask,
   output logic                    bubble,
   output logic                    illegal,
   output logic                    group_done
);

   localparam logic [LANES-1:0] ALL_LANES = {LANES{1'b1}};

   if (LANES < 1 || LANES > 32) begin : g_bad_lanes
      $error("simt_branch_seq: LANES must be 1..32");
   end
   if (PC_W < 1 || PC_W > TARGET_W) begin : g_bad_pcw
      $error("simt_branch_seq: PC_W must be 1..10");
   end

   cf_decode_t       dec;
   logic [LANES-1:0] lane_pass, exited;
   logic             any_pass;
   logic [PC_W-1:0]  pc_q, pc_d, jump_pc;
   logic             bubble_q, illegal_q;
   logic             retired, accept;
   logic             br_take, br_bad, do_resync, do_retire;

   simt_instr_decode #(.INSTR_W(64)) u_dec (
      .instr_i (instr),
      .dec_o   (dec)
   );

   simt_lane_cond #(.LANES(LANES)) u_cond (
      .flags_i    (lane_flags),
      .sel_i      (dec.comp_sel),
      .active_i   (active_mask),
      .pass_o     (lane_pass),
      .any_pass_o (any_pass)
   );

   if (PC_W == TARGET_W) begin : g_full_target
      assign jump_pc = dec.target;
   end else begin : g_narrow_target
      assign jump_pc = dec.target[PC_W-1:0];
   end

   assign retired   = (exited == ALL_LANES);
   assign accept    = instr_valid && !bubble_q && !retired;
   assign br_bad    = accept && (dec.kind == CF_BRANCH) && dec.rsv_bad;
   assign br_take   = accept && (dec.kind == CF_BRANCH) && !dec.rsv_bad && any_pass;
   assign do_resync = accept && (dec.kind == CF_RESYNC);
   assign do_retire = accept && (dec.kind == CF_RETIRE);

   simt_lane_mask #(.LANES(LANES)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (br_take),
      .pass_i   (lane_pass),
      .resync_i (do_resync),
      .retire_i (do_retire),
      .active_o (active_mask),
      .exited_o (exited),
      .done_o   (group_done)
   );

   always_comb begin
      if (br_take)                pc_d = jump_pc;
      else if (accept && !br_bad) pc_d = pc_q + PC_W'(1);
      else                        pc_d = pc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q      <= PC_W'(RESET_PC);
         bubble_q  <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         pc_q      <= pc_d;
         bubble_q  <= br_take;
         illegal_q <= br_bad;
      end
   end

   assign pc      = pc_q;
   assign bubble  = bubble_q;
   assign illegal = illegal_q;

   assert_bubble_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_q |-> $past(br_take));

   assert_bubble_discards_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_q |=> ($stable(pc_q) && $stable(active_mask)));

   assert_bad_branch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      br_bad |=> ($stable(pc_q) && $stable(active_mask)));

   assert_retired_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      retired |=> ($stable(pc_q) && $stable(active_mask) && !bubble_q));

   assert_one_command_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({br_take, br_bad, do_resync, do_retire}) <= 1);

endmodule

// File: tb/tb_simt_branch_seq.sv
`timescale 1ns/1ps
module tb_simt_branch_seq;

   typedef struct packed {
      logic [31:0] tag;
      logic [63:0] ins;
      logic [15:0] flg;
      logic [9:0]  pc;
      logic [3:0]  act;
      logic        bub;
      logic        ill;
      logic        dn;
   } row_t;

   function automatic logic [63:0] mk_br(input logic [3:0] sel, input logic [9:0] tgt);
      return {8'h80, sel, 10'b0, tgt, 32'b0};
   endfunction

   function automatic logic [63:0] mk_op(input logic [7:0] code);
      return {code, 56'b0};
   endfunction

   localparam int NROWS = 21;
   localparam row_t ROWS [NROWS] = '{
      '{"R2",  mk_op(8'h10),          16'h0000, 10'h001, 4'hF, 1'b0, 1'b0, 1'b0},
      '{"R3",  mk_br(4'h1, 10'h020),  16'h0101, 10'h020, 4'h5, 1'b1, 1'b0, 1'b0},
      '{"R6",  mk_op(8'h10),          16'h0000, 10'h020, 4'h5, 1'b0, 1'b0, 1'b0},
      '{"R4",  mk_br(4'h2, 10'h040),  16'h0020, 10'h021, 4'h5, 1'b0, 1'b0, 1'b0},
      '{"R3",  mk_br(4'h5, 10'h050),  16'h0105, 10'h050, 4'h1, 1'b1, 1'b0, 1'b0},
      '{"R6",  mk_op(8'h01),          16'h0000, 10'h050, 4'h1, 1'b0, 1'b0, 1'b0},
      '{"R7",  mk_op(8'h01),          16'h0000, 10'h051, 4'hF, 1'b0, 1'b0, 1'b0},
      '{"R5",  mk_br(4'h1, 10'h060) | 64'h0000_0400_0000_0000,
                                      16'hFFFF, 10'h051, 4'hF, 1'b0, 1'b1, 1'b0},
      '{"R5",  mk_br(4'h1, 10'h060) | 64'h1,
                                      16'hFFFF, 10'h051, 4'hF, 1'b0, 1'b1, 1'b0},
      '{"R10", mk_br(4'h0, 10'h3FF),  16'h0000, 10'h3FF, 4'hF, 1'b1, 1'b0, 1'b0},
      '{"R6",  mk_op(8'h21),          16'h0000, 10'h3FF, 4'hF, 1'b0, 1'b0, 1'b0},
      '{"R11", mk_op(8'h21),          16'h0000, 10'h000, 4'hF, 1'b0, 1'b0, 1'b0},
      '{"R3",  mk_br(4'h8, 10'h010),  16'h8080, 10'h010, 4'hA, 1'b1, 1'b0, 1'b0},
      '{"R6",  mk_op(8'h30),          16'h0000, 10'h010, 4'hA, 1'b0, 1'b0, 1'b0},
      '{"R8",  mk_op(8'h00),          16'h0000, 10'h011, 4'h0, 1'b0, 1'b0, 1'b0},
      '{"R4",  mk_br(4'h1, 10'h030),  16'hFFFF, 10'h012, 4'h0, 1'b0, 1'b0, 1'b0},
      '{"R7",  mk_op(8'h01),          16'h0000, 10'h013, 4'h5, 1'b0, 1'b0, 1'b0},
      '{"R9",  mk_op(8'h00),          16'h0000, 10'h014, 4'h0, 1'b0, 1'b0, 1'b1},
      '{"R9",  mk_op(8'h10),          16'h0000, 10'h014, 4'h0, 1'b0, 1'b0, 1'b0},
      '{"R9",  mk_op(8'h01),          16'h0000, 10'h014, 4'h0, 1'b0, 1'b0, 1'b0},
      '{"R9",  mk_op(8'h00),          16'h0000, 10'h014, 4'h0, 1'b0, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [63:0] instr = '0;
   logic [15:0] lane_flags = '0;
   logic [9:0]  pc;
   logic [3:0]  active_mask;
   logic        bubble, illegal, group_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   simt_branch_seq #(.LANES(4), .PC_W(10), .RESET_PC(0)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr       (instr),
      .lane_flags  (lane_flags),
      .pc          (pc),
      .active_mask (active_mask),
      .bubble      (bubble),
      .illegal     (illegal),
      .group_done  (group_done)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [9:0] e_pc, input logic [3:0] e_act,
                          input logic e_b, input logic e_i, input logic e_d);
      chk(req, "pc",          32'(pc),          32'(e_pc));
      chk(req, "active_mask", 32'(active_mask), 32'(e_act));
      chk(req, "bubble",      32'(bubble),      32'(e_b));
      chk(req, "illegal",     32'(illegal),     32'(e_i));
      chk(req, "group_done",  32'(group_done),  32'(e_d));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk_all("R1", 10'h000, 4'hF, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: one instruction per cycle, outputs sampled after the edge
      for (int k = 0; k < NROWS; k++) begin
         @(negedge clk);
         instr_valid = 1'b1;
         instr       = ROWS[k].ins;
         lane_flags  = ROWS[k].flg;
         @(posedge clk);
         #1;
         chk_all($sformatf("%s row %0d", ROWS[k].tag, k),
                 ROWS[k].pc, ROWS[k].act, ROWS[k].bub, ROWS[k].ill, ROWS[k].dn);
      end

      // R1: reset in the middle of a retired group restores the start state
      @(negedge clk);
      instr_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk_all("R1", 10'h000, 4'hF, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: no valid strobe, nothing moves
      @(negedge clk);
      instr_valid = 1'b0;
      instr = mk_br(4'h0, 10'h123);
      @(posedge clk);
      #1;
      chk_all("R2", 10'h000, 4'hF, 1'b0, 1'b0, 1'b0);

      // R3: a one-lane pass on lane 2 with a two-component select
      @(negedge clk);
      instr_valid = 1'b1;
      instr = mk_br(4'hC, 10'h2AA);
      lane_flags = 16'h3C00;
      @(posedge clk);
      #1;
      chk_all("R3", 10'h2AA, 4'h4, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      instr_valid = 1'b0;
      @(posedge clk);
      #1;
      chk("R6", "bubble drop", 32'(bubble), 32'd0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule